// File: doc/BRIEF.md
# Sparse Zero-Skipping Dot Product Engine

This block computes the dot product of one fixed-length vector of signed 8-bit weights with a vector of signed 8-bit activations. The pairs arrive one at a time on a valid/ready stream. Before any arithmetic, each operand whose magnitude falls below a threshold is forced to zero. Any pair that then holds a zero operand is counted as skipped and never reaches a multiplier.

The remaining pairs go through a round-robin arbiter to a small pool of multiply-accumulate lanes. Each lane has a fixed occupancy. A tally of issued plus skipped pairs marks the end of each vector. When the vector is complete and every lane has drained, the lane partial sums are added together. The total leaves on a second valid/ready stream as one signed word.

The threshold is taken from a configuration input once at the start of each vector. Changing that input while a vector is in progress therefore has no effect on that vector. The number of lanes and the lane occupancy are build-time parameters, so the lane pool can be sized to the sparsity a layer is expected to have.

Top module: `sparse_dot_engine`

## Requirements
- R1: An operand is clipped to zero when its magnitude is strictly less than the threshold. The threshold is an unsigned 8-bit value, and -128 has magnitude 128. A threshold of 0 clips nothing, and a threshold of 255 clips every operand.
- R2: A pair with a zero operand after clipping never occupies a lane. Such a pair is accepted in the cycle it is offered during a vector, even when every lane is busy.
- R3: Non-zero pairs are granted to free lanes in round-robin order, one pair per lane per grant. A lane that takes a pair can take its next one MAC_LAT+1 cycles later. in_ready is low for a non-zero pair when no lane is free. For an unbroken run of non-zero pairs with LANES <= MAC_LAT+1, pair k is accepted (k / LANES)*(MAC_LAT+1) + (k mod LANES) cycles after pair 0.
- R4: Exactly one result is emitted for every VEC_LEN accepted pairs, counting issued and skipped pairs. The result equals the signed sum of the products of the clipped operands. in_ready is low outside the accumulation phase.
- R5: A vector in which every pair is skipped produces exactly one result, and that result is 0.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_sum stays unchanged.
- R7: The threshold is captured from cfg_thresh in the first cycle after reset and in the cycle after each output handshake. Changes to cfg_thresh at any other time do not affect the vector in progress.
- R8: Accumulators and out_sum are 2*8 + clog2(VEC_LEN+1) bits wide. VEC_LEN full-scale products (-128 times -128, or -128 times 127) therefore sum without overflow.
- R9: During reset, out_valid and in_ready are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_thresh | input | 8 | Clipping threshold, unsigned; captured at the start of each vector |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Input pair accepted when high together with in_valid |
| in_w | input | 8 | Weight operand, signed |
| in_a | input | 8 | Activation operand, signed |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_sum | output | 2*8+clog2(VEC_LEN+1) | Signed dot product of the clipped vector |

## Verification
The assertions assume the following about the upstream side:
- it keeps a pair stable and does not withdraw in_valid while waiting;
- its operands are never unknown while valid is high;
- because in_ready depends on the pair offered, it never chooses the pair in reaction to in_ready.

The bench drives each pair at the falling edge and holds it until it sees in_ready just before the rising edge. It alters cfg_thresh only at falling edges, either after a vector's first pair has been accepted or right after its last. It switches random out_ready stalls on only once the timing checks on the input side are complete.

// File: rtl/spdot_pkg.sv
package spdot_pkg;

    localparam int OP_W = 8;

    typedef logic signed [OP_W-1:0] operand_t;

    typedef struct packed {
        operand_t w;
        operand_t a;
    } pair_t;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_EMIT  = 2'd3
    } eng_state_e;

    // Width that holds n full-scale signed products without overflow.
    function automatic int acc_width(input int n);
        return 2 * OP_W + $clog2(n + 1);
    endfunction

    // True when |v| < thr (thr unsigned; |-128| = 128).
    function automatic logic below_thr(input operand_t v, input logic [OP_W-1:0] thr);
        logic [OP_W:0] mag;
        mag = v[OP_W-1] ? ({1'b0, ~v} + 1'b1) : {1'b0, v};
        return mag < {1'b0, thr};
    endfunction

endpackage

// File: rtl/spdot_clip.sv
module spdot_clip
    import spdot_pkg::*;
(
    input  pair_t              raw,
    input  logic [OP_W-1:0]    thr,
    output pair_t              clipped,
    output logic               has_zero
);
    always_comb begin
        clipped.w = below_thr(raw.w, thr) ? '0 : raw.w;
        clipped.a = below_thr(raw.a, thr) ? '0 : raw.a;
        has_zero  = (clipped.w == '0) || (clipped.a == '0);
    end
endmodule

// File: rtl/spdot_rr_arb.sv
module spdot_rr_arb #(
    parameter int N_REQ = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_REQ-1:0] req,
    input  logic             take,
    output logic [N_REQ-1:0] grant,
    output logic             any
);
    localparam int PTR_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] sel;

    always_comb begin
        int idx;
        logic [PTR_W-1:0] idx_w;
        grant = '0;
        any   = 1'b0;
        sel   = '0;
        for (int i = 0; i < N_REQ; i++) begin
            idx   = (int'(ptr) + i) % N_REQ;
            idx_w = PTR_W'(idx);
            if (!any && req[idx_w]) begin
                any         = 1'b1;
                grant[idx_w] = 1'b1;
                sel         = idx_w;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (take && any) begin
            ptr <= (sel == PTR_W'(N_REQ - 1)) ? '0 : sel + 1'b1;
        end
    end

    assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_grant_only_free_R3: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);

endmodule

// File: rtl/spdot_mac_lane.sv
module spdot_mac_lane
    import spdot_pkg::*;
#(
    parameter int ACC_W   = 21,
    parameter int MAC_LAT = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    start,
    input  pair_t                   op,
    output logic                    free,
    output logic signed [ACC_W-1:0] acc
);
    localparam int CNT_W  = $clog2(MAC_LAT + 1);
    localparam int PROD_W = 2 * OP_W;

    logic [CNT_W-1:0]          cnt;
    logic signed [PROD_W-1:0]  prod;

    assign free = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt  <= '0;
            prod <= '0;
            acc  <= '0;
        end else if (start) begin
            prod <= op.w * op.a;
            cnt  <= CNT_W'(MAC_LAT);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
                acc <= acc + {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
            end
        end
    end

    // A lane must never be handed a pair while still busy.
    assert_lane_idle_on_start_R3: assert property (@(posedge clk) disable iff (rst)
        start |-> cnt == '0);

    // Accumulator is cleared only between vectors, when the lane is idle.
    assert_clear_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
        clr |-> free && !start);

endmodule

// File: rtl/spdot_tally.sv
module spdot_tally #(
    parameter int VEC_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic issue,
    input  logic skip,
    output logic last
);
    localparam int CW = $clog2(VEC_LEN + 1);

    logic [CW-1:0] n_issued;
    logic [CW-1:0] n_skipped;
    logic [CW:0]   seen;

    assign seen = {1'b0, n_issued} + {1'b0, n_skipped};
    assign last = (seen == (CW + 1)'(VEC_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            n_issued  <= '0;
            n_skipped <= '0;
        end else begin
            n_issued  <= n_issued + CW'(issue);
            n_skipped <= n_skipped + CW'(skip);
        end
    end

    assert_single_kind_R2: assert property (@(posedge clk) disable iff (rst)
        !(issue && skip));

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
        seen <= (CW + 1)'(VEC_LEN));

endmodule

// File: rtl/sparse_dot_engine.sv
module sparse_dot_engine
    import spdot_pkg::*;
#(
    parameter int VEC_LEN = 16,
    parameter int LANES   = 2,
    parameter int MAC_LAT = 3,
    localparam int ACC_W  = acc_width(VEC_LEN)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [OP_W-1:0]         cfg_thresh,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic signed [OP_W-1:0]  in_w,
    input  logic signed [OP_W-1:0]  in_a,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic signed [ACC_W-1:0] out_sum
);
    eng_state_e              state_q;
    logic [OP_W-1:0]         thr_q;
    pair_t                   raw_pair;
    pair_t                   clip_pair;
    logic                    pair_zero;
    logic [LANES-1:0]        lane_free;
    logic [LANES-1:0]        lane_grant;
    logic [LANES-1:0]        lane_start;
    logic                    lane_any;
    logic signed [ACC_W-1:0] lane_acc [LANES];
    logic signed [ACC_W-1:0] sum_all;
    logic signed [ACC_W-1:0] result_q;
    logic                    fire, fire_nz, fire_z, vec_last;
    logic                    in_load;

    assign raw_pair = '{w: in_w, a: in_a};
    assign in_load  = (state_q == ST_LOAD);

    spdot_clip u_clip (
        .raw      (raw_pair),
        .thr      (thr_q),
        .clipped  (clip_pair),
        .has_zero (pair_zero)
    );

    spdot_rr_arb #(.N_REQ(LANES)) u_arb (
        .clk   (clk),
        .rst   (rst),
        .req   (lane_free),
        .take  (fire_nz),
        .grant (lane_grant),
        .any   (lane_any)
    );

    assign in_ready = (state_q == ST_RUN) && (pair_zero || lane_any);
    assign fire     = in_valid && in_ready;
    assign fire_nz  = fire && !pair_zero;
    assign fire_z   = fire && pair_zero;
    assign lane_start = fire_nz ? lane_grant : '0;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        spdot_mac_lane #(.ACC_W(ACC_W), .MAC_LAT(MAC_LAT)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .clr   (in_load),
            .start (lane_start[g]),
            .op    (clip_pair),
            .free  (lane_free[g]),
            .acc   (lane_acc[g])
        );
    end

    spdot_tally #(.VEC_LEN(VEC_LEN)) u_tally (
        .clk   (clk),
        .rst   (rst),
        .clr   (in_load),
        .issue (fire_nz),
        .skip  (fire_z),
        .last  (vec_last)
    );

    always_comb begin
        sum_all = '0;
        for (int i = 0; i < LANES; i++) begin
            sum_all = sum_all + lane_acc[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_LOAD;
            thr_q    <= '0;
            result_q <= '0;
        end else begin
            case (state_q)
                ST_LOAD: begin
                    thr_q   <= cfg_thresh;
                    state_q <= ST_RUN;
                end
                ST_RUN: begin
                    if (fire && vec_last) state_q <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (&lane_free) begin
                        result_q <= sum_all;
                        state_q  <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (out_ready) state_q <= ST_LOAD;
                end
                default: state_q <= ST_LOAD;
            endcase
        end
    end

    assign out_valid = (state_q == ST_EMIT);
    assign out_sum   = result_q;

    assert_zero_never_issued_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && pair_zero) |-> lane_start == '0);

    assert_nonzero_takes_one_lane_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !pair_zero) |-> $onehot(lane_start));

    assert_no_input_outside_run_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_RUN) |-> !in_ready);

    assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid && $stable(out_sum));

    assert_thr_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_LOAD) |=> $stable(thr_q));

endmodule

// File: tb/sim_sparse_dot_engine.sv
module sim_sparse_dot_engine;
    localparam int N     = 16;
    localparam int L     = 2;
    localparam int LAT   = 3;
    localparam int ACC_W = 2 * 8 + $clog2(N + 1);

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic                    rst;
    logic [7:0]              cfg_thresh;
    logic                    in_valid;
    logic                    in_ready;
    logic signed [7:0]       in_w, in_a;
    logic                    out_valid;
    logic                    out_ready = 1'b0;
    logic signed [ACC_W-1:0] out_sum;

    sparse_dot_engine #(.VEC_LEN(N), .LANES(L), .MAC_LAT(LAT)) u0 (
        .clk(clk), .rst(rst), .cfg_thresh(cfg_thresh),
        .in_valid(in_valid), .in_ready(in_ready), .in_w(in_w), .in_a(in_a),
        .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    wv[N];
    int    av[N];
    int    acc_cyc[N];
    int    exp_q[$];
    string tag_q[$];
    int    vec_sent = 0;
    int    results_seen = 0;
    bit    bp_on = 1'b0;
    bit    hold_pending = 1'b0;
    logic signed [ACC_W-1:0] hold_val;

    function automatic int clipv(input int v, input int t);
        int m;
        m = (v < 0) ? -v : v;
        return (m < t) ? 0 : v;
    endfunction

    function automatic int dot_exp(input int t);
        int s;
        s = 0;
        for (int i = 0; i < N; i++) s += clipv(wv[i], t) * clipv(av[i], t);
        return s;
    endfunction

    function automatic int rnd_op();
        if ($urandom % 4 == 0) return 0;
        return int'($urandom_range(0, 255)) - 128;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: pushes the expected sum, then feeds the vector pair by pair.
    task automatic send_vec(input int thr_cur, input int thr_next, input bit garble, input string tag);
        exp_q.push_back(dot_exp(thr_cur));
        tag_q.push_back(tag);
        vec_sent++;
        for (int i = 0; i < N; i++) begin
            bit done;
            done = 1'b0;
            @(negedge clk);
            if (garble && i == 1) cfg_thresh = 8'(thr_cur ^ 8'h5A);
            in_valid = 1'b1;
            in_w = 8'(wv[i]);
            in_a = 8'(av[i]);
            while (!done) begin
                #9;
                if (in_ready) done = 1'b1;
                @(posedge clk);
                acc_cyc[i] = cyc;
                if (!done) @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        cfg_thresh = 8'(thr_next);
    endtask

    // Monitor: pops expected items as results are handed over.
    always @(negedge clk) begin
        if (!rst) begin
            if (hold_pending) begin
                check(out_valid && out_sum == hold_val, "R6 held result",
                      int'(out_sum), int'(hold_val));
                hold_pending = 1'b0;
            end
            out_ready = bp_on ? ($urandom % 4 != 0) : 1'b1;
            if (out_valid && out_ready) begin
                results_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected extra result", int'(out_sum), 0);
                end else begin
                    int    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(int'(out_sum) == e, t, int'(out_sum), e);
                end
            end else if (out_valid) begin
                hold_pending = 1'b1;
                hold_val = out_sum;
            end
        end
    end

    task automatic run_all();
        int t_cur, t_next;
        // Mixed random vector, threshold 0
        for (int i = 0; i < N; i++) begin wv[i] = rnd_op(); av[i] = rnd_op(); end
        send_vec(0, 0, 1'b0, "R4 mixed vector");
        // Full-scale positive products, unbroken non-zero run
        for (int i = 0; i < N; i++) begin wv[i] = -128; av[i] = -128; end
        send_vec(0, 0, 1'b0, "R8 full-scale -128*-128");
        for (int k = 0; k < N; k++) begin
            int e;
            e = (k / L) * (LAT + 1) + (k % L);
            check(acc_cyc[k] - acc_cyc[0] == e, "R3 round-robin accept timing",
                  acc_cyc[k] - acc_cyc[0], e);
        end
        // Full-scale negative products
        for (int i = 0; i < N; i++) begin wv[i] = -128; av[i] = 127; end
        send_vec(0, 255, 1'b0, "R8 full-scale -128*127");
        // Threshold 255 clips everything
        for (int i = 0; i < N; i++) begin
            wv[i] = (i % 2) ? -128 : 127 - i;
            av[i] = 100 + i;
        end
        send_vec(255, 0, 1'b0, "R1 threshold 255 clips all");
        // All zero operands
        for (int i = 0; i < N; i++) begin wv[i] = 0; av[i] = (i % 3 == 0) ? 0 : 50; end
        send_vec(0, 20, 1'b0, "R5 all-skipped vector");
        // Boundary around threshold 20, threshold input disturbed mid-vector
        for (int i = 0; i < N; i++) begin
            case (i % 8)
                0: wv[i] = 19;   1: wv[i] = 20;   2: wv[i] = -19;  3: wv[i] = -20;
                4: wv[i] = 21;   5: wv[i] = -128; 6: wv[i] = 1;    default: wv[i] = 127;
            endcase
            av[i] = (i < 8) ? 30 - i : -(i + 15);
        end
        send_vec(20, 5, 1'b1, "R1 R7 boundary at threshold 20");
        // Two non-zero pairs, then pairs that are zero after clipping
        wv[0] = 30;  av[0] = -40;
        wv[1] = -60; av[1] = 70;
        for (int i = 2; i < N; i++) begin
            case (i % 3)
                0: begin wv[i] = 4;   av[i] = 100; end
                1: begin wv[i] = 0;   av[i] = -90; end
                default: begin wv[i] = 100; av[i] = -3; end
            endcase
        end
        send_vec(5, 0, 1'b0, "R2 R4 sparse vector");
        for (int k = 1; k < N; k++) begin
            check(acc_cyc[k] - acc_cyc[0] == k, "R2 zero pair bypasses busy lanes",
                  acc_cyc[k] - acc_cyc[0], k);
        end
        // Random vectors with output stalls and disturbed threshold input
        bp_on = 1'b1;
        t_cur = 0;
        for (int j = 0; j < 8; j++) begin
            t_next = int'($urandom_range(0, 40));
            for (int i = 0; i < N; i++) begin wv[i] = rnd_op(); av[i] = rnd_op(); end
            send_vec(t_cur, t_next, 1'b1, "R6 R7 random vector with stalls");
            t_cur = t_next;
        end
        wait (exp_q.size() == 0);
        repeat (6) @(negedge clk);
        check(results_seen == vec_sent, "R4 one result per vector", results_seen, vec_sent);
    endtask

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        in_w = '0;
        in_a = '0;
        cfg_thresh = 8'd0;
        repeat (3) @(negedge clk);
        check(!out_valid, "R9 out_valid low in reset", int'(out_valid), 0);
        check(!in_ready, "R9 in_ready low in reset", int'(in_ready), 0);
        rst = 1'b0;
        fork
            run_all();
            begin
                wait (cyc >= 100000);
                check(1'b0, "watchdog expired", cyc, 100000);
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule